// File: doc/BRIEF.md
# Message-Signalled Interrupt Pending and Dispatch Engine

This block turns per-vector interrupt requests from a PCIe endpoint application into memory write requests for the link. It holds a vector table with one entry per vector: a message address split into a lower and an upper word, a message data word and a mask bit. It also holds a pending bit array packed 64 bits to a QWORD. A request sets the vector's pending bit. A state machine then looks up the entry of the lowest-numbered vector that is pending and unmasked. It builds a one-dword memory write header and hands the header and data word downstream over a valid/ready handshake.

A masked vector keeps its pending bit until software clears the mask through the register port. The engine then dispatches it with no further request. The header has three dwords when the upper address word is zero and four dwords otherwise. Only one write is in flight at a time. The pending bit is cleared only when the downstream side accepts the write.

The state machine has three states. ST_IDLE waits for a pending, unmasked vector. The pick transition latches its index and moves to ST_LOOKUP. ST_LOOKUP reads the entry. The issue transition latches header and data and moves to ST_SEND. If the mask was set in the meantime, the drop transition returns to ST_IDLE and the bit stays pending. ST_SEND presents the write. The accept transition (valid and ready both high) clears the pending bit and returns to ST_IDLE.

Top module: `msix_dispatch_top`

## Requirements
- R1: After reset `tx_valid` is low and every pending bit reads zero.
- R2: A request on `irq_valid`/`irq_vec` for vector n sets pending bit (n mod 64) of QWORD (n div 64). QWORD k reads at byte address PBA_BASE + 8k (default 0x800). Its bits 31:0 are at offset +0 and bits 63:32 at offset +4.
- R3: A vector whose mask bit is set issues no write, and its pending bit stays set.
- R4: For an unmasked vector with the engine idle, `tx_valid` is low after the request edge and after the next edge, and high after the second edge following the request edge.
- R5: When the entry's upper address is zero, `tx_hdr4` is 0 and the header is laid out as follows. Dword 0 in `tx_hdr[31:0]` is 0x40000001: format 010 in bits 31:29, type 00000 in bits 28:24, length 1 in bits 9:0. Dword 1 in `tx_hdr[63:32]` is 0x0000000F (first byte enable 1111). Dword 2 holds the lower address with bits 1:0 zero. Dword 3 in `tx_hdr[127:96]` is zero. `tx_data` is the entry's data word.
- R6: When the upper address is nonzero, `tx_hdr4` is 1. Dword 0 is 0x60000001 (format 011), dword 1 is 0x0000000F, dword 2 is the upper address and dword 3 is the lower address with bits 1:0 zero.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_hdr` and `tx_data` hold. No other vector is presented until the current write is accepted.
- R8: A vector's pending bit stays set while its write waits and clears on the accepting edge. A new request for the same vector on that edge leaves it set and causes a second dispatch.
- R9: Clearing the mask of a vector that is already pending dispatches it without a new request.
- R10: When several unmasked vectors are pending, they are dispatched from the lowest index upward.
- R11: Register writes to the pending array have no effect on it.
- R12: Entry n occupies bytes n*16 to n*16+15: lower address at +0 (bits 1:0 read zero), upper address at +4, data at +8, control at +12 with the mask in bit 0. Masks reset to 1 and the other fields to 0. Accesses with nonzero address bits 1:0 write nothing and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | $clog2(NUM_VEC) | Requested vector index |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tx_valid | output | 1 | Memory write request valid |
| tx_ready | input | 1 | Downstream accepts the request |
| tx_hdr | output | 128 | Header dwords 0 to 3, dword 0 in the low bits |
| tx_data | output | 32 | Message data word |
| tx_hdr4 | output | 1 | 1 for a four-dword header |

## Verification
If a pending bit is lost or set wrongly, it shows at the pending array read port on the next cycle. It also shows as a missing or extra write two cycles after the state machine would have picked the vector. A wrong scan order or a stuck in-flight state shows at the first accept, when the next `tx_data` names the wrong vector or `tx_valid` never rises again. Header selection faults appear in the first dword of the very write that triggers them, because the format bits and the position of the lower address both change with the upper address word.

// File: rtl/msix_pkg.sv
package msix_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_SEND
    } disp_state_e;

    localparam logic [2:0] FMT_3DW_DATA = 3'b010;
    localparam logic [2:0] FMT_4DW_DATA = 3'b011;
    localparam logic [4:0] TYPE_MEM     = 5'b00000;
    localparam logic [9:0] LEN_ONE_DW   = 10'd1;
    localparam logic [3:0] BE_ALL       = 4'hF;

    typedef struct packed {
        logic [29:0] addr_lo;
        logic [31:0] addr_hi;
        logic [31:0] data;
        logic        mask;
    } vec_entry_t;

endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
    import msix_pkg::*;
#(
    parameter int NUM_VEC  = 72,
    parameter int VEC_W    = 7,
    parameter int REG_AW   = 12,
    parameter int PBA_BASE = 'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [VEC_W-1:0]  sel_idx,
    output vec_entry_t        sel_entry,
    output logic [NUM_VEC-1:0] mask_vec
);

    localparam logic [REG_AW-1:0] PBA_A = REG_AW'(PBA_BASE);
    localparam logic [REG_AW-5:0] N_ENT = (REG_AW-4)'(NUM_VEC);

    logic             tbl_hit;
    logic [VEC_W-1:0] ent_idx;
    logic [1:0]       fld;
    vec_entry_t       ent_a [NUM_VEC];

    assign tbl_hit = (addr < PBA_A) && (addr[REG_AW-1:4] < N_ENT) && (addr[1:0] == 2'b00);
    assign ent_idx = addr[VEC_W+3:4];
    assign fld     = addr[3:2];

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_entry
        vec_entry_t ent_r;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_r <= '{addr_lo: '0, addr_hi: '0, data: '0, mask: 1'b1};
            end else if (wr_en && tbl_hit && (ent_idx == VEC_W'(g))) begin
                unique case (fld)
                    2'd0: ent_r.addr_lo <= wdata[31:2];
                    2'd1: ent_r.addr_hi <= wdata;
                    2'd2: ent_r.data    <= wdata;
                    2'd3: ent_r.mask    <= wdata[0];
                endcase
            end
        end

        assign ent_a[g]    = ent_r;
        assign mask_vec[g] = ent_r.mask;
    end

    always_comb begin
        rdata = '0;
        if (tbl_hit) begin
            unique case (fld)
                2'd0: rdata = {ent_a[ent_idx].addr_lo, 2'b00};
                2'd1: rdata = ent_a[ent_idx].addr_hi;
                2'd2: rdata = ent_a[ent_idx].data;
                2'd3: rdata = {31'd0, ent_a[ent_idx].mask};
            endcase
        end
    end

    assign sel_entry = ent_a[sel_idx];

endmodule

// File: rtl/msix_pend_array.sv
module msix_pend_array #(
    parameter int NUM_VEC  = 72,
    parameter int VEC_W    = 7,
    parameter int REG_AW   = 12,
    parameter int PBA_BASE = 'h800
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [VEC_W-1:0]   set_idx,
    input  logic               clr_en,
    input  logic [VEC_W-1:0]   clr_idx,
    input  logic [NUM_VEC-1:0] mask_vec,
    input  logic [REG_AW-1:0]  addr,
    output logic [31:0]        rdata,
    output logic [NUM_VEC-1:0] pend_vec,
    output logic               hit,
    output logic [VEC_W-1:0]   hit_idx
);

    localparam int QWORDS = (NUM_VEC - 1) / 64 + 1;
    localparam int DWORDS = QWORDS * 2;
    localparam int PAD_W  = DWORDS * 32;
    localparam logic [REG_AW-1:0] PBA_A = REG_AW'(PBA_BASE);

    logic [NUM_VEC-1:0] pend_q, set_m, clr_m;
    logic [PAD_W-1:0]   pend_pad;
    logic [REG_AW-3:0]  dw_off;
    logic               in_pba;

    always_comb begin
        for (int i = 0; i < NUM_VEC; i++) begin
            set_m[i] = set_en && (set_idx == VEC_W'(i));
            clr_m[i] = clr_en && (clr_idx == VEC_W'(i));
        end
    end

    // set has priority over a clear on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_m) | set_m;
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (pend_q[i] && !mask_vec[i]) begin
                hit     = 1'b1;
                hit_idx = VEC_W'(i);
            end
        end
    end

    assign pend_pad = PAD_W'(pend_q);
    assign in_pba   = (addr >= PBA_A) && (addr[1:0] == 2'b00);
    assign dw_off   = addr[REG_AW-1:2] - PBA_A[REG_AW-1:2];

    always_comb begin
        rdata = '0;
        for (int d = 0; d < DWORDS; d++) begin
            if (in_pba && (dw_off == (REG_AW-2)'(d))) rdata = pend_pad[d*32 +: 32];
        end
    end

    assign pend_vec = pend_q;

endmodule

// File: rtl/msix_tlp_build.sv
module msix_tlp_build
    import msix_pkg::*;
(
    input  logic [29:0]  addr_lo,
    input  logic [31:0]  addr_hi,
    input  logic [31:0]  data_in,
    output logic [127:0] hdr,
    output logic [31:0]  data_out,
    output logic         is4
);

    logic [31:0] dw0, dw1, dw2, dw3;

    always_comb begin
        is4 = (addr_hi != 32'd0);
        dw0 = {(is4 ? FMT_4DW_DATA : FMT_3DW_DATA), TYPE_MEM, 14'd0, LEN_ONE_DW};
        dw1 = {16'd0, 8'd0, 4'd0, BE_ALL};
        if (is4) begin
            dw2 = addr_hi;
            dw3 = {addr_lo, 2'b00};
        end else begin
            dw2 = {addr_lo, 2'b00};
            dw3 = 32'd0;
        end
        hdr      = {dw3, dw2, dw1, dw0};
        data_out = data_in;
    end

endmodule

// File: rtl/msix_dispatch_top.sv
module msix_dispatch_top
    import msix_pkg::*;
#(
    parameter int NUM_VEC  = 72,
    parameter int REG_AW   = 12,
    parameter int PBA_BASE = 'h800,
    localparam int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_valid,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [127:0]      tx_hdr,
    output logic [31:0]       tx_data,
    output logic              tx_hdr4
);

    disp_state_e        state_q, state_d;
    logic [VEC_W-1:0]   cur_idx_q;
    logic [127:0]       hdr_q;
    logic [31:0]        data_q;
    logic               is4_q;

    logic [NUM_VEC-1:0] mask_vec, pend_vec;
    logic               hit, accept;
    logic [VEC_W-1:0]   hit_idx;
    vec_entry_t         sel_entry;
    logic [31:0]        tbl_rd, pend_rd, bld_data;
    logic [127:0]       bld_hdr;
    logic               bld_is4;

    msix_vec_table #(
        .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .REG_AW(REG_AW), .PBA_BASE(PBA_BASE)
    ) table_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(tbl_rd), .sel_idx(cur_idx_q), .sel_entry(sel_entry), .mask_vec(mask_vec)
    );

    msix_pend_array #(
        .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .REG_AW(REG_AW), .PBA_BASE(PBA_BASE)
    ) pend_i (
        .clk(clk), .rst_n(rst_n), .set_en(irq_valid), .set_idx(irq_vec),
        .clr_en(accept), .clr_idx(cur_idx_q), .mask_vec(mask_vec), .addr(reg_addr),
        .rdata(pend_rd), .pend_vec(pend_vec), .hit(hit), .hit_idx(hit_idx)
    );

    msix_tlp_build build_i (
        .addr_lo(sel_entry.addr_lo), .addr_hi(sel_entry.addr_hi), .data_in(sel_entry.data),
        .hdr(bld_hdr), .data_out(bld_data), .is4(bld_is4)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: pick, issue, drop, accept
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (hit) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = sel_entry.mask ? ST_IDLE : ST_SEND;
            ST_SEND:   if (tx_ready) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx_q <= '0;
            hdr_q     <= '0;
            data_q    <= '0;
            is4_q     <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && hit) cur_idx_q <= hit_idx;
            if (state_q == ST_LOOKUP && !sel_entry.mask) begin
                hdr_q  <= bld_hdr;
                data_q <= bld_data;
                is4_q  <= bld_is4;
            end
        end
    end

    // outputs
    always_comb begin
        tx_valid  = (state_q == ST_SEND);
        accept    = tx_valid && tx_ready;
        tx_hdr    = hdr_q;
        tx_data   = data_q;
        tx_hdr4   = is4_q;
        reg_rdata = tbl_rd | pend_rd;
    end

endmodule

// File: rtl/msix_dispatch_chk.sv
module msix_dispatch_chk #(
    parameter int NUM_VEC = 72,
    parameter int VEC_W   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_valid,
    input logic [VEC_W-1:0]   irq_vec,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic [127:0]       tx_hdr,
    input logic [31:0]        tx_data,
    input logic [NUM_VEC-1:0] pend,
    input logic [NUM_VEC-1:0] mask_vec,
    input logic [VEC_W-1:0]   cur_idx
);

    localparam logic [VEC_W-1:0] LAST_VEC = VEC_W'(NUM_VEC - 1);

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_hdr) && $stable(tx_data)); // R7

    AST_SET_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && (irq_vec <= LAST_VEC) |=> pend[$past(irq_vec)]); // R2

    AST_PEND_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> pend[cur_idx]); // R8

    AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && !(irq_valid && irq_vec == cur_idx) |=> !pend[$past(cur_idx)]); // R8

    AST_NO_MASKED_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> !$past(mask_vec[cur_idx])); // R3

endmodule

bind msix_dispatch_top msix_dispatch_chk #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_hdr(tx_hdr), .tx_data(tx_data),
    .pend(pend_vec), .mask_vec(mask_vec), .cur_idx(cur_idx_q)
);

// File: tb/msix_dispatch_top_tb.sv
module msix_dispatch_top_tb_top;

    localparam int NUM_VEC = 72;
    localparam int VEC_W   = $clog2(NUM_VEC);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         irq_valid = 1'b0;
    logic [VEC_W-1:0] irq_vec = '0;
    logic         reg_wr = 1'b0;
    logic [11:0]  reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         tx_valid;
    logic         tx_ready = 1'b0;
    logic [127:0] tx_hdr;
    logic [31:0]  tx_data;
    logic         tx_hdr4;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    msix_dispatch_top #(.NUM_VEC(NUM_VEC)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_vec(irq_vec),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_hdr(tx_hdr), .tx_data(tx_data),
        .tx_hdr4(tx_hdr4)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp=<50000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic prog(input int n, input logic [31:0] lo, input logic [31:0] hi,
                        input logic [31:0] data, input logic mask);
        wr(12'(n * 16),      lo);
        wr(12'(n * 16 + 4),  hi);
        wr(12'(n * 16 + 8),  data);
        wr(12'(n * 16 + 12), {31'd0, mask});
    endtask

    task automatic fire(input int n);
        @(negedge clk);
        irq_valid = 1'b1; irq_vec = VEC_W'(n);
        @(negedge clk);
        irq_valid = 1'b0;
    endtask

    task automatic wait_valid(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tx_valid) begin seen = 1'b1; break; end
        end
    endtask

    task automatic accept_tx();
        @(negedge clk);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    function automatic logic [127:0] exp_hdr(input logic [31:0] lo, input logic [31:0] hi);
        logic [31:0] l;
        l = {lo[31:2], 2'b00};
        if (hi != 0) return {l, hi, 32'h0000_000F, 32'h6000_0001};
        else         return {32'h0, l, 32'h0000_000F, 32'h4000_0001};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk(tx_valid == 1'b0, "R1 tx_valid after reset", 128'(tx_valid), 0);
        for (int k = 0; k < 4; k++) begin
            rd(12'(12'h800 + k * 4), d);
            chk(d == 0, "R1 pending dword after reset", 128'(d), 0);
        end
        rd(12'h00C, d);
        chk(d == 1, "R12 mask resets to 1", 128'(d), 1);
    endtask

    task automatic t_masked();
        logic [31:0] d;
        int seen;
        seen = 0;
        fire(66);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (tx_valid) seen++;
        end
        chk(seen == 0, "R3 masked vector issued no write", 128'(seen), 0);
        rd(12'h808, d);
        chk(d == 32'h4, "R2 vector 66 in QWORD 1 bit 2", 128'(d), 128'h4);
        fire(40);
        rd(12'h804, d);
        chk(d == 32'h100, "R2 vector 40 in QWORD 0 upper dword bit 8", 128'(d), 128'h100);
        rd(12'h808, d);
        chk(d == 32'h4, "R3 masked vector 66 stays pending", 128'(d), 128'h4);
    endtask

    task automatic t_pend_ro();
        logic [31:0] d;
        wr(12'h808, 32'h0);
        wr(12'h804, 32'h0);
        rd(12'h808, d);
        chk(d == 32'h4, "R11 write to pending QWORD 1 ignored", 128'(d), 128'h4);
        rd(12'h804, d);
        chk(d == 32'h100, "R11 write to pending QWORD 0 hi ignored", 128'(d), 128'h100);
        wr(12'h800, 32'hFFFF_FFFF);
        rd(12'h800, d);
        chk(d == 0, "R11 set via write ignored", 128'(d), 0);
    endtask

    task automatic t_unmask();
        logic [31:0] d;
        logic [127:0] h0;
        bit seen;
        prog(66, 32'hFEE0_0013, 32'h0, 32'h4042, 1'b1);
        rd(12'(66 * 16), d);
        chk(d == 32'hFEE0_0010, "R12 lower address bits 1:0 read zero", 128'(d), 128'hFEE0_0010);
        rd(12'(66 * 16 + 1), d);
        chk(d == 0, "R12 unaligned read returns zero", 128'(d), 0);
        wr(12'(66 * 16 + 12), 32'h0);
        wait_valid(seen);
        chk(seen, "R9 unmask dispatches pending vector", 128'(seen), 1);
        chk(tx_hdr == exp_hdr(32'hFEE0_0013, 32'h0), "R5 three-dword header", tx_hdr,
            exp_hdr(32'hFEE0_0013, 32'h0));
        chk(tx_hdr4 == 1'b0, "R5 tx_hdr4 low", 128'(tx_hdr4), 0);
        chk(tx_data == 32'h4042, "R5 data word", 128'(tx_data), 128'h4042);
        h0 = tx_hdr;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(tx_valid && tx_hdr == h0 && tx_data == 32'h4042, "R7 held while not ready",
                tx_hdr, h0);
        end
        rd(12'h808, d);
        chk(d == 32'h4, "R8 pending held until accept", 128'(d), 128'h4);
        accept_tx();
        rd(12'h808, d);
        chk(d == 0, "R8 pending cleared on accept", 128'(d), 0);
        rd(12'h804, d);
        chk(d == 32'h100, "R3 masked vector 40 untouched", 128'(d), 128'h100);
    endtask

    task automatic t_four_dw();
        logic [31:0] d;
        prog(5, 32'h2000_0008, 32'h0000_0001, 32'hA5, 1'b0);
        rd(12'h5C, d);
        chk(d == 0, "R12 control readback mask 0", 128'(d), 0);
        @(negedge clk);
        irq_valid = 1'b1; irq_vec = VEC_W'(5);
        @(posedge clk);
        @(negedge clk);
        irq_valid = 1'b0;
        chk(tx_valid == 1'b0, "R4 low after request edge", 128'(tx_valid), 0);
        @(posedge clk); #1;
        chk(tx_valid == 1'b0, "R4 low after first edge", 128'(tx_valid), 0);
        @(posedge clk); #1;
        chk(tx_valid == 1'b1, "R4 high after second edge", 128'(tx_valid), 1);
        chk(tx_hdr == exp_hdr(32'h2000_0008, 32'h1), "R6 four-dword header", tx_hdr,
            exp_hdr(32'h2000_0008, 32'h1));
        chk(tx_hdr4 == 1'b1, "R6 tx_hdr4 high", 128'(tx_hdr4), 1);
        chk(tx_data == 32'hA5, "R6 data word", 128'(tx_data), 128'hA5);
        accept_tx();
    endtask

    task automatic t_order();
        bit seen;
        int extra;
        for (int n = 1; n <= 6; n++)
            if (n == 1 || n == 2 || n == 6)
                prog(n, 32'hFEE0_0000 + 32'(n * 16), 32'h0, 32'h4000 + 32'(n), 1'b0);
        fire(6);
        wait_valid(seen);
        chk(seen && tx_data == 32'h4006, "R10 first vector 6", 128'(tx_data), 128'h4006);
        fire(2);
        fire(1);
        repeat (3) @(negedge clk);
        chk(tx_valid && tx_data == 32'h4006, "R7 one write in flight", 128'(tx_data), 128'h4006);
        accept_tx();
        wait_valid(seen);
        chk(seen && tx_data == 32'h4001, "R10 lowest pending next", 128'(tx_data), 128'h4001);
        accept_tx();
        wait_valid(seen);
        chk(seen && tx_data == 32'h4002, "R10 then vector 2", 128'(tx_data), 128'h4002);
        accept_tx();
        extra = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (tx_valid) extra++;
        end
        chk(extra == 0, "R8 no write after all accepted", 128'(extra), 0);
    endtask

    task automatic t_rereq();
        logic [31:0] d;
        bit seen;
        fire(2);
        wait_valid(seen);
        chk(seen && tx_data == 32'h4002, "R8 vector 2 presented", 128'(tx_data), 128'h4002);
        @(negedge clk);
        tx_ready = 1'b1; irq_valid = 1'b1; irq_vec = VEC_W'(2);
        @(negedge clk);
        tx_ready = 1'b0; irq_valid = 1'b0;
        rd(12'h800, d);
        chk(d[2] == 1'b1, "R8 re-request on accept keeps pending", 128'(d), 128'h4);
        wait_valid(seen);
        chk(seen && tx_data == 32'h4002, "R8 second dispatch", 128'(tx_data), 128'h4002);
        accept_tx();
        rd(12'h800, d);
        chk(d[2] == 1'b0, "R8 cleared after second accept", 128'(d), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked();
        t_pend_ro();
        t_unmask();
        t_four_dw();
        t_order();
        t_rereq();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule